// File: doc/BRIEF.md
# Serial ADC Output Sequencer

This block is the digital half of a 12-bit micropower sampling converter's three-wire serial port. It watches an active-low select line that also acts as the shutdown control, and a data clock from the host. From these it produces a serial data output with an enable for a tri-state pad. Each exchange runs in a fixed order. The block samples, then enables the pad and sends a low null bit. Next it sends the conversion result with the most significant bit first, then sends the same result again least significant bit first, and after that sends zeros for as long as the clock keeps running.

The conversion result comes in on a parallel input. It is captured on the data-clock fall that sends the null bit, which is the moment conversion starts. The block also drives a power-down flag. The flag is high whenever the port is deselected, and it rises again once the last bit of the first word has been sent, even if select stays low. The host clock is sampled in the system clock domain. One exchange takes at least 16 data-clock periods, so the sample rate is the data-clock rate divided by 16.

Top module: `adc_serial_seq`

## Requirements
- R1: While `cs_ni` is high the block is deselected. One system clock after `cs_ni` is sampled high, `dout_oe_o` and `dout_o` are both low. Data-clock edges have no effect while deselected.
- R2: The first falling edge of `dclk_i` after `cs_ni` falls leaves `dout_oe_o` low. The second falling edge sets `dout_oe_o` high.
- R3: The second falling edge drives `dout_o` low. This is the null bit.
- R4: `code_i` is captured on the second falling edge. Changing it afterwards does not change the bits that are sent.
- R5: Falling edges 3 through 14 drive bit 11 down to bit 0 of the captured code, as straight binary. Falling edge k drives bit 14-k.
- R6: Falling edges 15 through 25 drive bits 1 through 11 in rising order. Falling edge k drives bit k-14.
- R7: From falling edge 26 onward, `dout_o` is 0 and `dout_oe_o` stays high while `cs_ni` stays low.
- R8: `pd_o` is high while `cs_ni` is high and goes low together with `cs_ni`. It rises on falling edge 14, when bit 0 goes out, and stays high for the rest of the exchange.
- R9: `dout_o` and `dout_oe_o` change only one system clock after a sampled falling edge of `dclk_i` or a high `cs_ni`. Rising data-clock edges change nothing.
- R10: Raising `cs_ni` in the middle of an exchange aborts it, as in R1. The next fall of `cs_ni` starts again from the first falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Select, active low; high means shutdown |
| dclk_i | input | 1 | Host data clock, synchronous to clk_i |
| code_i | input | 12 | Conversion result to send |
| dout_o | output | 1 | Serial data |
| dout_oe_o | output | 1 | Output enable for the serial data pad |
| pd_o | output | 1 | Converter power-down flag |

## Verification
The data outputs register a data-clock fall one system clock after the edge where the low level is first sampled. The bench therefore changes `dclk_i` on a falling system-clock edge and checks on the falling edge that comes one full period later. It checks the previous bit after every data-clock rise, which confirms that a rise leaves the output unchanged. `pd_o` follows `cs_ni` combinationally together with the registered edge count, so it is checked on the same schedule as the data. Deselection is checked one period after `cs_ni` rises.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    PH_SAMPLE,
    PH_NULL,
    PH_MSB,
    PH_LSB,
    PH_ZERO
  } phase_e;
endpackage

// File: rtl/adc_dclk_edge.sv
module adc_dclk_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dclk_i,
  output logic fall_o
);
  logic dclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dclk_q <= 1'b0;
    else         dclk_q <= dclk_i;
  end

  assign fall_o = dclk_q & ~dclk_i;
endmodule

// File: rtl/adc_seq_ctr.sv
module adc_seq_ctr
  import adc_seq_pkg::*;
#(
  parameter  int WIDTH    = 12,
  localparam int NULL_IDX = 2,
  localparam int MSB_END  = NULL_IDX + WIDTH,
  localparam int ZERO_IDX = MSB_END + WIDTH,
  localparam int CW       = $clog2(ZERO_IDX + 1),
  localparam int IW       = $clog2(WIDTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          fall_i,
  output logic [CW-1:0] cnt_o,
  output phase_e        phase_o,
  output logic [IW-1:0] bit_idx_o
);
  logic [CW-1:0] cnt_q, nxt;
  int            nxt_i;

  // saturate once the zero tail is reached
  assign nxt   = (int'(cnt_q) == ZERO_IDX) ? cnt_q : cnt_q + CW'(1);
  assign nxt_i = int'(nxt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cs_ni)  cnt_q <= '0;
    else if (fall_i) cnt_q <= nxt;
  end

  always_comb begin
    phase_o   = PH_SAMPLE;
    bit_idx_o = '0;
    if (nxt_i >= ZERO_IDX) begin
      phase_o = PH_ZERO;
    end else if (nxt_i > MSB_END) begin
      phase_o   = PH_LSB;
      bit_idx_o = IW'(nxt_i - MSB_END);
    end else if (nxt_i > NULL_IDX) begin
      phase_o   = PH_MSB;
      bit_idx_o = IW'(MSB_END - nxt_i);
    end else if (nxt_i == NULL_IDX) begin
      phase_o = PH_NULL;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/adc_shift_out.sv
module adc_shift_out
  import adc_seq_pkg::*;
#(
  parameter  int WIDTH = 12,
  localparam int IW    = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             fall_i,
  input  phase_e           phase_i,
  input  logic [IW-1:0]    bit_idx_i,
  input  logic [WIDTH-1:0] code_i,
  output logic             dout_o,
  output logic             oe_o
);
  logic [WIDTH-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
    end else if (!cs_ni && fall_i && phase_i == PH_NULL) begin
      code_q <= code_i;  // conversion start
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_o <= 1'b0;
      oe_o   <= 1'b0;
    end else if (cs_ni) begin
      dout_o <= 1'b0;
      oe_o   <= 1'b0;
    end else if (fall_i) begin
      case (phase_i)
        PH_SAMPLE: begin oe_o <= 1'b0; dout_o <= 1'b0; end
        PH_NULL:   begin oe_o <= 1'b1; dout_o <= 1'b0; end
        PH_MSB,
        PH_LSB:    begin oe_o <= 1'b1; dout_o <= code_q[bit_idx_i]; end
        default:   begin oe_o <= 1'b1; dout_o <= 1'b0; end
      endcase
    end
  end
endmodule

// File: rtl/adc_serial_seq.sv
module adc_serial_seq
  import adc_seq_pkg::*;
#(
  parameter  int WIDTH   = 12,
  localparam int MSB_END = 2 + WIDTH,
  localparam int CW      = $clog2(MSB_END + WIDTH + 1),
  localparam int IW      = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             dclk_i,
  input  logic [WIDTH-1:0] code_i,
  output logic             dout_o,
  output logic             dout_oe_o,
  output logic             pd_o
);
  logic          fall;
  logic [CW-1:0] cnt;
  phase_e        phase;
  logic [IW-1:0] bit_idx;

  adc_dclk_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .dclk_i (dclk_i),
    .fall_o (fall)
  );

  adc_seq_ctr #(.WIDTH(WIDTH)) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_ni     (cs_ni),
    .fall_i    (fall),
    .cnt_o     (cnt),
    .phase_o   (phase),
    .bit_idx_o (bit_idx)
  );

  adc_shift_out #(.WIDTH(WIDTH)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_ni     (cs_ni),
    .fall_i    (fall),
    .phase_i   (phase),
    .bit_idx_i (bit_idx),
    .code_i    (code_i),
    .dout_o    (dout_o),
    .oe_o      (dout_oe_o)
  );

  // comparator and bias off once the last conversion bit is out
  assign pd_o = cs_ni | (int'(cnt) >= MSB_END);
endmodule

// File: rtl/adc_serial_seq_chk.sv
module adc_serial_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_ni,
  input logic dclk_i,
  input logic dout_o,
  input logic dout_oe_o,
  input logic pd_o
);
  // R1
  desel_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> !dout_oe_o);

  // R1
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dout_oe_o |-> !dout_o);

  // R3
  null_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dout_oe_o) |-> !dout_o);

  // R8
  pd_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pd_o) |-> $fell(cs_ni));

  // R8
  pd_late_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pd_o) && !cs_ni) |-> dout_oe_o);

  // R9
  dout_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !$fell(dclk_i)) |=> ($stable(dout_o) && $stable(dout_oe_o)));
endmodule

bind adc_serial_seq adc_serial_seq_chk u_chk (.*);

// File: tb/sim_adc_serial_seq.sv
`timescale 1ns/1ps
module sim_adc_serial_seq;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_ni = 1'b1;
  logic        dclk = 1'b0;
  logic [11:0] code = '0;
  logic        dout, oe, pd;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  adc_serial_seq u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .dclk_i(dclk),
    .code_i(code), .dout_o(dout), .dout_oe_o(oe), .pd_o(pd)
  );

  // {oe, dout} after k data-clock falls
  function automatic logic [1:0] expect_out(int k, logic [11:0] c);
    if (k < 2)       return 2'b00;
    else if (k == 2) return 2'b10;
    else if (k <= 14) return {1'b1, c[14-k]};
    else if (k <= 25) return {1'b1, c[k-14]};
    else             return 2'b10;
  endfunction

  function automatic string tag_of(int k);
    if (k < 2)        return "R2";
    else if (k == 2)  return "R3";
    else if (k <= 14) return "R4/R5";
    else if (k <= 25) return "R4/R6";
    else              return "R7";
  endfunction

  task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run(logic [11:0] c, int nf);
    logic [1:0] prev;
    code = c;
    @(negedge clk) cs_ni = 1'b0;
    @(negedge clk);
    chk("R8 pd low on select", {1'b0, pd}, 2'b00);
    chk("R2 idle before falls", {oe, dout}, 2'b00);
    prev = 2'b00;
    for (int k = 1; k <= nf; k++) begin
      dclk = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R9 rise holds", {oe, dout}, prev);
      dclk = 1'b0;
      @(negedge clk);
      @(negedge clk);
      prev = expect_out(k, c);
      chk(tag_of(k), {oe, dout}, prev);
      chk("R8 pd", {1'b0, pd}, {1'b0, (k >= 14)});
      if (k == 2) code = ~c;  // later changes must not leak (R4)
    end
    cs_ni = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1/R10 deselect", {oe, dout}, 2'b00);
    chk("R8 pd on deselect", {1'b0, pd}, 2'b01);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 reset outputs", {oe, dout}, 2'b00);
    chk("R1 reset pd", {1'b0, pd}, 2'b01);

    // clocking while deselected changes nothing (R1)
    for (int i = 0; i < 4; i++) begin
      @(negedge clk) dclk = 1'b1;
      @(negedge clk) dclk = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R1 clocks ignored", {oe, dout}, 2'b00);
    end

    run(12'h000, 30);
    run(12'hFFF, 30);
    run(12'hA5A, 30);
    run(12'h5A5, 30);
    run(12'h001, 28);
    run(12'h800, 28);
    for (int i = 0; i < 24; i++) run(12'((i * 1365 + 7) % 4096), 28);

    // abort mid-word then restart (R10)
    run(12'hABC, 7);
    run(12'h3C3, 30);
    run(12'h9E1, 1);
    run(12'h6B2, 16);

    finish_up();
  end
endmodule